// File: doc/BRIEF.md
# Sobel Gradient Threshold Unit

This block is the arithmetic core of a streaming edge detector. Each clock it may accept one complete 3x3 neighbourhood of 8-bit grey levels, together with the row and column index of the centre pixel, a valid flag and an 11-bit threshold. It forms the horizontal and vertical Sobel responses and adds their absolute values to get a magnitude with no square root. It then compares the magnitude with the threshold and produces a one-bit edge decision and an 8-bit output pixel.

A pixel whose row index or column index is below 2 is treated as a border pixel. It is not convolved and always comes out as a zero pixel, so the output image has the same size as the input image. The datapath has three register stages. The valid flag and both indices travel through the pipeline with the data, so a downstream writer can place each result without any counting of its own.

Top module: `sobel_edge_unit`

## Requirements
- R1: `in_win` packs the window row-major with z1 (top-left) in bits [7:0] and z9 (bottom-right) in bits [71:64]. The horizontal response is Gx = (z1 + 2·z2 + z3) − (z7 + 2·z8 + z9), which is positive when the top row is brighter.
- R2: The vertical response is Gy = (z3 + 2·z6 + z9) − (z1 + 2·z4 + z7), which is positive when the right column is brighter.
- R3: The magnitude is |Gx| + |Gy|, computed exactly over the full range 0..2040 with no saturation.
- R4: A non-border pixel is an edge only when the magnitude is strictly greater than the threshold. A magnitude equal to or below the threshold gives a non-edge.
- R5: When `in_row` < 2 or `in_col` < 2, the result is a non-edge with pixel 8'h00, whatever the window and threshold. Row 2, column 2 is convolved normally.
- R6: `out_pix` is 8'hFF when `out_edge` is 1 and 8'h00 otherwise, on every valid output.
- R7: Each accepted input (`in_valid` = 1) produces exactly one output exactly 3 clock cycles later, with `out_row` and `out_col` equal to the indices given with it. Cycles with `in_valid` = 0 produce no output.
- R8: A synchronous active-high `rst` clears every valid stage. `out_valid` is 0 in the cycle after reset, and inputs accepted before reset produce no output.
- R9: The threshold is taken together with each valid window, so consecutive windows may use different thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Window, indices and threshold are valid this cycle |
| in_win | input | 72 | 3x3 neighbourhood, z1 in the low byte, z9 in the high byte |
| in_row | input | 12 | Row index of the centre pixel |
| in_col | input | 12 | Column index of the centre pixel |
| in_thresh | input | 11 | Edge threshold for this window |
| out_valid | output | 1 | Result valid |
| out_edge | output | 1 | Edge decision |
| out_pix | output | 8 | Output grey level (8'hFF edge, 8'h00 otherwise) |
| out_row | output | 12 | Row index carried with the result |
| out_col | output | 12 | Column index carried with the result |

## Verification
Some properties are checked on every cycle:
- the three-cycle valid and index latency;
- the fixed pixel code for edge and non-edge;
- zero output on border indices;
- the strict comparison between the registered magnitude and its threshold;
- the clearing effect of reset.

The Sobel arithmetic itself (signs, tap weights, the absolute-value sum and the boundary between equal and greater magnitudes) can only be shown by the bench's windows with known gradients. The same applies to thresholds changing back to back and to the discarding of in-flight inputs across a mid-stream reset.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    localparam int PIX_W  = 8;
    localparam int NTAP   = 9;
    localparam int WIN_W  = PIX_W * NTAP;
    localparam int IDX_W  = 12;
    localparam int SUM_W  = PIX_W + 2;   // weighted triple, up to 4*255
    localparam int MAG_W  = PIX_W + 3;   // two absolute differences, up to 2040
    localparam int NARM   = 4;           // top, bottom, right, left

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [SUM_W-1:0] sum_t;
    typedef logic [MAG_W-1:0] mag_t;
    typedef logic [IDX_W-1:0] idx_t;

    localparam pix_t PIX_ON  = '1;
    localparam pix_t PIX_OFF = '0;

    // Sideband carried alongside the arithmetic
    typedef struct packed {
        logic valid;
        logic border;
        idx_t row;
        idx_t col;
        mag_t thr;
    } tag_t;

    typedef struct packed {
        tag_t            tag;
        sum_t [NARM-1:0] arm;
    } arms_t;

    typedef struct packed {
        tag_t tag;
        mag_t mag;
    } grad_t;

    typedef struct packed {
        logic valid;
        logic hit;
        pix_t pix;
        idx_t row;
        idx_t col;
    } result_t;

    function automatic sum_t weighted3(pix_t a, pix_t m, pix_t b);
        return {2'b00, a} + {1'b0, m, 1'b0} + {2'b00, b};
    endfunction

    // |p - q| on unsigned sums; never needs a signed intermediate
    function automatic mag_t absdiff(sum_t p, sum_t q);
        sum_t d;
        d = (p >= q) ? (p - q) : (q - p);
        return {{(MAG_W-SUM_W){1'b0}}, d};
    endfunction

endpackage

// File: rtl/sobel_arms.sv
module sobel_arms
    import sobel_pkg::*;
#(
    parameter int BORDER_LIM = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIN_W-1:0] in_win,
    input  idx_t             in_row,
    input  idx_t             in_col,
    input  mag_t             in_thresh,
    output arms_t            arms_q
);

    // Tap triples (outer, middle, outer) for each weighted arm
    localparam int TAP_SEL [NARM][3] = '{
        '{0, 1, 2},   // top row
        '{6, 7, 8},   // bottom row
        '{2, 5, 8},   // right column
        '{0, 3, 6}    // left column
    };

    arms_t arms_d;

    for (genvar k = 0; k < NARM; k++) begin : g_arm
        assign arms_d.arm[k] = weighted3(in_win[TAP_SEL[k][0]*PIX_W +: PIX_W],
                                         in_win[TAP_SEL[k][1]*PIX_W +: PIX_W],
                                         in_win[TAP_SEL[k][2]*PIX_W +: PIX_W]);
    end

    assign arms_d.tag.valid  = in_valid;
    assign arms_d.tag.border = (in_row < idx_t'(BORDER_LIM)) || (in_col < idx_t'(BORDER_LIM));
    assign arms_d.tag.row    = in_row;
    assign arms_d.tag.col    = in_col;
    assign arms_d.tag.thr    = in_thresh;

    always_ff @(posedge clk) begin
        arms_q <= arms_d;
        if (rst) arms_q.tag.valid <= 1'b0;
    end

endmodule

// File: rtl/sobel_mag.sv
module sobel_mag
    import sobel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  arms_t arms_q,
    output grad_t grad_q
);

    grad_t grad_d;

    // arm[0]-arm[1] is Gx, arm[2]-arm[3] is Gy
    assign grad_d.tag = arms_q.tag;
    assign grad_d.mag = absdiff(arms_q.arm[0], arms_q.arm[1])
                      + absdiff(arms_q.arm[2], arms_q.arm[3]);

    always_ff @(posedge clk) begin
        grad_q <= grad_d;
        if (rst) grad_q.tag.valid <= 1'b0;
    end

endmodule

// File: rtl/sobel_decide.sv
module sobel_decide
    import sobel_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  grad_t   grad_q,
    output result_t res_q
);

    result_t res_d;

    assign res_d.valid = grad_q.tag.valid;
    assign res_d.hit   = !grad_q.tag.border && (grad_q.mag > grad_q.tag.thr);
    assign res_d.pix   = res_d.hit ? PIX_ON : PIX_OFF;
    assign res_d.row   = grad_q.tag.row;
    assign res_d.col   = grad_q.tag.col;

    always_ff @(posedge clk) begin
        res_q <= res_d;
        if (rst) res_q.valid <= 1'b0;
    end

endmodule

// File: rtl/sobel_edge_unit.sv
module sobel_edge_unit
    import sobel_pkg::*;
#(
    parameter int BORDER_LIM = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIN_W-1:0] in_win,
    input  logic [IDX_W-1:0] in_row,
    input  logic [IDX_W-1:0] in_col,
    input  logic [MAG_W-1:0] in_thresh,
    output logic             out_valid,
    output logic             out_edge,
    output logic [PIX_W-1:0] out_pix,
    output logic [IDX_W-1:0] out_row,
    output logic [IDX_W-1:0] out_col
);

    arms_t   s1_q;
    grad_t   s2_q;
    result_t s3_q;

    sobel_arms #(.BORDER_LIM(BORDER_LIM)) u_arms (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_win    (in_win),
        .in_row    (in_row),
        .in_col    (in_col),
        .in_thresh (in_thresh),
        .arms_q    (s1_q)
    );

    sobel_mag u_mag (
        .clk    (clk),
        .rst    (rst),
        .arms_q (s1_q),
        .grad_q (s2_q)
    );

    sobel_decide u_decide (
        .clk    (clk),
        .rst    (rst),
        .grad_q (s2_q),
        .res_q  (s3_q)
    );

    assign out_valid = s3_q.valid;
    assign out_edge  = s3_q.hit;
    assign out_pix   = s3_q.pix;
    assign out_row   = s3_q.row;
    assign out_col   = s3_q.col;

endmodule

// File: rtl/sobel_edge_checks.sv
module sobel_edge_checks
    import sobel_pkg::*;
#(
    parameter int BORDER_LIM = 2
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input idx_t in_row,
    input idx_t in_col,
    input logic out_valid,
    input logic out_edge,
    input pix_t out_pix,
    input idx_t out_row,
    input idx_t out_col,
    input logic mid_valid,
    input logic mid_border,
    input mag_t mid_mag,
    input mag_t mid_thr
);

    // Cycles since reset, saturating at the pipeline depth
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_valid_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_index_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid) |->
            (out_row == $past(in_row, 3) && out_col == $past(in_col, 3)));

    p_pix_code_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_pix == (out_edge ? PIX_ON : PIX_OFF)));

    p_border_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_row < idx_t'(BORDER_LIM) || out_col < idx_t'(BORDER_LIM)))
            |-> (!out_edge && out_pix == PIX_OFF));

    p_above_thresh_r4: assert property (@(posedge clk) disable iff (rst)
        (mid_valid && !mid_border && mid_mag > mid_thr) |=> out_edge);

    p_not_above_thresh_r4: assert property (@(posedge clk) disable iff (rst)
        (mid_valid && mid_mag <= mid_thr) |=> !out_edge);

    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind sobel_edge_unit sobel_edge_checks #(.BORDER_LIM(BORDER_LIM)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_row     (in_row),
    .in_col     (in_col),
    .out_valid  (out_valid),
    .out_edge   (out_edge),
    .out_pix    (out_pix),
    .out_row    (out_row),
    .out_col    (out_col),
    .mid_valid  (s2_q.tag.valid),
    .mid_border (s2_q.tag.border),
    .mid_mag    (s2_q.mag),
    .mid_thr    (s2_q.tag.thr)
);

// File: tb/test_sobel_edge_unit.sv
module test_sobel_edge_unit;

    typedef struct packed {
        logic [71:0] win;
        logic [11:0] row;
        logic [11:0] col;
        logic [10:0] thr;
        logic        hit;
    } vec_t;

    // win packs {z9,...,z1}; z1 is the low byte
    localparam logic [71:0] W_ZERO  = 72'h000000000000000000;
    localparam logic [71:0] W_TOP   = 72'h000000000000FFFFFF; // Gx=+1020, Gy=0
    localparam logic [71:0] W_RIGHT = 72'hFF0000FF0000FF0000; // Gx=0, Gy=+1020
    localparam logic [71:0] W_BOT   = 72'hFFFFFF000000000000; // Gx=-1020, Gy=0
    localparam logic [71:0] W_Z1    = 72'h0000000000000000FF; // Gx=+255, Gy=-255
    localparam logic [71:0] W_MIX   = 72'hFF0000FF0000FFFFFF; // Gx=765, Gy=765
    localparam logic [71:0] W_SMALL = 72'h000000030000000A00; // z2=10,z6=3: 20+6
    localparam logic [71:0] W_LEFT  = 72'h000000000028000000; // z4=40: Gy=-80

    localparam int NV = 18;
    localparam vec_t TABLE [NV] = '{
        '{W_ZERO,  12'd5, 12'd5, 11'd0,    1'b0},  // R4 0 == 0 is not an edge
        '{W_TOP,   12'd5, 12'd5, 11'd1019, 1'b1},  // R1 positive Gx
        '{W_TOP,   12'd5, 12'd5, 11'd1020, 1'b0},  // R4 equal, R9 new threshold next cycle
        '{W_RIGHT, 12'd5, 12'd5, 11'd1019, 1'b1},  // R2 positive Gy
        '{W_RIGHT, 12'd5, 12'd5, 11'd1020, 1'b0},  // R2 / R9
        '{W_BOT,   12'd6, 12'd7, 11'd1019, 1'b1},  // R1 negative Gx
        '{W_Z1,    12'd7, 12'd8, 11'd509,  1'b1},  // R3 |255|+|-255| = 510
        '{W_Z1,    12'd7, 12'd8, 11'd510,  1'b0},  // R3
        '{W_MIX,   12'd9, 12'd9, 11'd1529, 1'b1},  // R3 1530
        '{W_MIX,   12'd9, 12'd9, 11'd1530, 1'b0},  // R3
        '{W_SMALL, 12'd3, 12'd4, 11'd25,   1'b1},  // R1 R2 weights, 26
        '{W_LEFT,  12'd4, 12'd3, 11'd80,   1'b0},  // R2 negative Gy, 80
        '{W_LEFT,  12'd4, 12'd3, 11'd79,   1'b1},  // R2
        '{W_TOP,   12'd1, 12'd5, 11'd0,    1'b0},  // R5 row border
        '{W_TOP,   12'd5, 12'd1, 11'd0,    1'b0},  // R5 column border
        '{W_TOP,   12'd0, 12'd0, 11'd0,    1'b0},  // R5 corner
        '{W_TOP,   12'd2, 12'd2, 11'd0,    1'b1},  // R5 first interior pixel
        '{W_TOP,   12'd5, 12'd5, 11'd2047, 1'b0}   // R4 top threshold
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [71:0] in_win = '0;
    logic [11:0] in_row = '0;
    logic [11:0] in_col = '0;
    logic [10:0] in_thresh = '0;
    logic        out_valid;
    logic        out_edge;
    logic [7:0]  out_pix;
    logic [11:0] out_row;
    logic [11:0] out_col;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int oidx = 0;
    bit mon_en = 1'b0;
    int sent_cyc [NV];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    sobel_edge_unit i_sobel_edge_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_win    (in_win),
        .in_row    (in_row),
        .in_col    (in_col),
        .in_thresh (in_thresh),
        .out_valid (out_valid),
        .out_edge  (out_edge),
        .out_pix   (out_pix),
        .out_row   (out_row),
        .out_col   (out_col)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Result monitor for the table stream
    always @(negedge clk) begin
        if (mon_en && out_valid) begin
            if (oidx < NV) begin
                chk(out_edge == TABLE[oidx].hit, $sformatf("R4 edge vec %0d", oidx),
                    int'(out_edge), int'(TABLE[oidx].hit));
                chk(out_pix == (TABLE[oidx].hit ? 8'hFF : 8'h00), $sformatf("R6 pix vec %0d", oidx),
                    int'(out_pix), TABLE[oidx].hit ? 255 : 0);
                chk(out_row == TABLE[oidx].row && out_col == TABLE[oidx].col,
                    $sformatf("R7 index vec %0d", oidx),
                    int'({out_row, out_col}), int'({TABLE[oidx].row, TABLE[oidx].col}));
                chk(cyc - sent_cyc[oidx] == 3, $sformatf("R7 latency vec %0d", oidx),
                    cyc - sent_cyc[oidx], 3);
            end else begin
                chk(1'b0, "R7 extra output", oidx, NV - 1);
            end
            oidx++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R8 reset state", int'(out_valid), 0);
        rst = 1'b0;
        mon_en = 1'b1;

        // Table walk, one window per cycle (R9: threshold changes back to back)
        for (int i = 0; i < NV; i++) begin
            in_valid  = 1'b1;
            in_win    = TABLE[i].win;
            in_row    = TABLE[i].row;
            in_col    = TABLE[i].col;
            in_thresh = TABLE[i].thr;
            sent_cyc[i] = cyc;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        mon_en = 1'b0;
        chk(oidx == NV, "R7 output count", oidx, NV);

        // Invalid cycles carry data but give no output (R7)
        in_win    = W_TOP;
        in_row    = 12'd5;
        in_col    = 12'd5;
        in_thresh = 11'd0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R7 idle no output", int'(out_valid), 0);
        end

        // Reset while an input is in flight discards it (R8)
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid == 1'b0, "R8 after reset", int'(out_valid), 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R8 flushed input", int'(out_valid), 0);
        end

        // A single window after reset still arrives 3 cycles later (R7)
        in_valid  = 1'b1;
        in_row    = 12'd8;
        in_col    = 12'd9;
        in_thresh = 11'd100;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 not early", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1 && out_edge == 1'b1 && out_row == 12'd8 && out_col == 12'd9,
            "R7 single after reset", int'({out_valid, out_edge}), 3);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 single pulse", int'(out_valid), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule